// File: doc/BRIEF.md
# Timer Capture/Compare Unit with Shared Channel

This block is a 16-bit free-running counter with a selectable clock divider, four compare channels that drive their own output levels, three capture channels that snapshot the counter on selected pin edges, and one shared channel. The shared channel uses a single 16-bit register and a single pin. It serves either as a fifth compare channel or as a fourth capture channel. A byte-wide register bus reaches all registers, and a single interrupt line combines every flag whose enable bit is set.

Software sets a compare value, an output action and an enable bit, then waits for the interrupt or polls the flag. For captures, software chooses the edge sense for each channel and reads back the latched count. When the shared pin is driven by the block itself and the shared channel is in capture mode, the driven level is also what the capture logic watches. Software can therefore timestamp its own pin writes.

Register map (byte addresses, 16-bit values with the high byte at the even address): 0x00 counter, 0x02/0x04/0x06/0x08 compare 1 to 4, 0x0A shared channel, 0x0C/0x0E/0x10 capture 1 to 3, 0x12 flags, 0x13 enables, 0x14 force, 0x15 control, 0x16 compare actions, 0x17 edge select, 0x18 overflow.

Top module: `tmr_capcmp`

## Requirements
- R1: The counter advances once every 1, 4, 8 or 16 clocks, selected by control bits [1:0] = 00, 01, 10, 11. Its divider phase starts at zero on reset, so with divide-by-N the first increment lands on clock edge N after reset.
- R2: The counter counts up through all 16-bit values. On the step from 0xFFFF to 0x0000 it sets the overflow flag, which is bit 7 of 0x18. Bit 6 of 0x18 enables the overflow interrupt. Writing 1 to bit 7 clears the flag.
- R3: A compare flag sets on the same clock edge at which the counter takes the value held in that channel's compare register.
- R4: On a match, each compare channel applies its 2-bit action: 00 none, 01 toggle, 10 clear, 11 set. Channel k (1 to 4) uses bits [2k-1:2k-2] of 0x16, and the shared channel uses control bits [5:4].
- R5: A capture channel latches the counter value present just before the edge at which it sees a qualifying pin change, and sets its flag. Edge select for channel k is bits [2k-1:2k-2] of 0x17: 00 off, 01 rising, 10 falling, 11 both. The shared channel uses bits [7:6].
- R6: The flag register holds compare 1 to 4 in bits 7 to 4, the shared channel in bit 3, and capture 1 to 3 in bits 2 to 0. The enable register at 0x13 uses the same bit positions. Writing 1 clears a flag; writing 0 leaves it unchanged.
- R7: Writing 1 to bit 7, 6, 5, 4 or 3 of 0x14 applies the action of compare 1, 2, 3, 4 or the shared compare at once, without setting any flag.
- R8: After reset the shared channel is a compare channel. Control bit 2 set to 1 makes it a capture channel. In that mode, bus writes to 0x0A/0x0B are ignored and captures land in that register.
- R9: Control bit 3 enables the shared pin output. While bit 3 is set, the shared channel watches the driven level instead of the pin input. In capture mode, control bit 6 supplies that driven level, so writing it produces captures.
- R10: The interrupt line is high whenever any flag and its enable bit are both 1.
- R11: Reading a high byte of a 16-bit register snapshots its low byte. A following read of that register's low byte returns the snapshot. A low-byte read with no pending snapshot for the same register returns the live value.
- R12: After reset, all registers, flags, output levels, the interrupt line and the pin enable are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register byte address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe, drives the read snapshot logic |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| cap_in | input | 3 | Capture pins, bit 0 is capture channel 1 |
| sh_pin_in | input | 1 | Shared pin input level |
| sh_pin_out | output | 1 | Shared pin driven level |
| sh_pin_oe | output | 1 | Shared pin output enable |
| cmp_out | output | 4 | Compare levels, bit 0 is compare channel 1 |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the capture pins and the shared pin input are already synchronous to the clock, because the block samples them with one register and no synchronizer. The stimulus changes every pin and bus input on the falling clock edge only. The assertions also treat a bus write and a capture in the same cycle as a case where the capture wins, so the stimulus keeps each capture edge apart from any bus write to the same register.

// File: rtl/tmr_capcmp.sv
`timescale 1ns/1ps
module tmr_capcmp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [2:0] cap_in,
  input  logic       sh_pin_in,
  output logic       sh_pin_out,
  output logic       sh_pin_oe,
  output logic [3:0] cmp_out,
  output logic       irq
);
  localparam logic [4:0] A_FLG = 5'h12, A_IEN = 5'h13, A_FRC = 5'h14, A_CTL = 5'h15,
                         A_ACT = 5'h16, A_EDG = 5'h17, A_OVF = 5'h18;

  logic [15:0] cnt;
  logic [3:0]  pre;
  logic [7:0]  ctrl, act, edg, flags, ien, rbuf;
  logic        ovf_f, ovf_en, rvalid;
  logic [3:0]  rpair;
  logic [15:0] cmpr [5];
  logic [15:0] capr [3];
  logic [4:0]  olvl, match, fire, frc;
  logic [3:0]  src, prev, hit;
  logic [7:0]  setv;
  logic [15:0] word;

  wire        sh_cap = ctrl[2];
  wire [3:0]  mask   = {ctrl[1:0] == 2'b11, ctrl[1], |ctrl[1:0], |ctrl[1:0]};
  wire        tick   = (pre & mask) == mask;
  wire [15:0] cnt_nx = cnt + 16'd1;

  function automatic logic apply(input logic [1:0] a, input logic l);
    case (a)
      2'b01:   apply = ~l;
      2'b10:   apply = 1'b0;
      2'b11:   apply = 1'b1;
      default: apply = l;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < 5; i++) match[i] = tick && (cnt_nx == cmpr[i]);
    match[4] = match[4] && !sh_cap;
    src = {ctrl[3] ? ctrl[6] : sh_pin_in, cap_in};
    for (int j = 0; j < 4; j++)
      hit[j] = (edg[2*j] & src[j] & ~prev[j]) | (edg[2*j+1] & ~src[j] & prev[j]);
    hit[3] = hit[3] && sh_cap;
    setv = {match[0], match[1], match[2], match[3], sh_cap ? hit[3] : match[4], hit[0], hit[1], hit[2]};
    frc  = (wr && addr == A_FRC) ? wdata[7:3] : 5'd0;
    for (int i = 0; i < 5; i++) fire[i] = match[i] | frc[4-i];
    fire[4] = fire[4] && !sh_cap;
  end

  always_comb begin
    case (addr[4:1])
      4'd0:    word = cnt;
      4'd1:    word = cmpr[0];
      4'd2:    word = cmpr[1];
      4'd3:    word = cmpr[2];
      4'd4:    word = cmpr[3];
      4'd5:    word = cmpr[4];
      4'd6:    word = capr[0];
      4'd7:    word = capr[1];
      4'd8:    word = capr[2];
      default: word = 16'd0;
    endcase
  end

  always_comb begin
    rdata = 8'h00;
    if (addr < A_FLG)
      rdata = addr[0] ? ((rvalid && rpair == addr[4:1]) ? rbuf : word[7:0]) : word[15:8];
    else
      case (addr)
        A_FLG:   rdata = flags;
        A_IEN:   rdata = ien;
        A_CTL:   rdata = ctrl;
        A_ACT:   rdata = act;
        A_EDG:   rdata = edg;
        A_OVF:   rdata = {ovf_f, ovf_en, 6'd0};
        default: rdata = 8'h00;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pre <= '0; ctrl <= '0; act <= '0; edg <= '0; flags <= '0; ien <= '0;
      rbuf <= '0; rpair <= '0; rvalid <= 1'b0; ovf_f <= 1'b0; ovf_en <= 1'b0;
      olvl <= '0; prev <= '0;
      for (int i = 0; i < 5; i++) cmpr[i] <= '0;
      for (int j = 0; j < 3; j++) capr[j] <= '0;
    end else begin
      pre <= pre + 4'd1;
      if (tick) cnt <= cnt_nx;
      if (tick && cnt == 16'hFFFF) ovf_f <= 1'b1;
      else if (wr && addr == A_OVF && wdata[7]) ovf_f <= 1'b0;
      if (wr && addr == A_OVF) ovf_en <= wdata[6];
      flags <= (flags & ~((wr && addr == A_FLG) ? wdata : 8'h00)) | setv;
      if (wr) begin
        case (addr)
          A_IEN: ien  <= wdata;
          A_CTL: ctrl <= wdata;
          A_ACT: act  <= wdata;
          A_EDG: edg  <= wdata;
          default: ;
        endcase
      end
      prev <= src;
      for (int i = 0; i < 4; i++) if (fire[i]) olvl[i] <= apply(act[2*i +: 2], olvl[i]);
      if (fire[4]) olvl[4] <= apply(ctrl[5:4], olvl[4]);
      for (int i = 0; i < 5; i++)
        if (wr && addr[4:1] == 4'(i + 1) && !(i == 4 && sh_cap)) begin
          if (addr[0]) cmpr[i][7:0] <= wdata;
          else         cmpr[i][15:8] <= wdata;
        end
      for (int j = 0; j < 3; j++) if (hit[j]) capr[j] <= cnt;
      if (hit[3]) cmpr[4] <= cnt;
      if (rd && addr < A_FLG) begin
        if (!addr[0]) begin
          rbuf <= word[7:0]; rpair <= addr[4:1]; rvalid <= 1'b1;
        end else rvalid <= 1'b0;
      end
    end
  end

  assign cmp_out    = olvl[3:0];
  assign sh_pin_oe  = ctrl[3];
  assign sh_pin_out = sh_cap ? ctrl[6] : olvl[4];
  assign irq        = |(flags & ien) | (ovf_f & ovf_en);
endmodule

module tmr_capcmp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr,
  input logic [4:0]  addr,
  input logic [7:0]  wdata,
  input logic [15:0] cnt,
  input logic [7:0]  ctrl,
  input logic [7:0]  flags,
  input logic [7:0]  ien,
  input logic        ovf_f,
  input logic        irq,
  input logic [4:0]  match,
  input logic [3:0]  hit,
  input logic [15:0] sh_reg
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 16'd1));
  assert_div1_every_clock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1:0] == 2'b00) |=> (cnt == $past(cnt) + 16'd1));
  assert_wrap_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 16'h0000 && $past(cnt) == 16'hFFFF) |-> ovf_f);
  assert_shared_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2] && wr && addr[4:1] == 4'd5 && !hit[3]) |=> (sh_reg == $past(sh_reg)));
  assert_force_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 5'h14 && wdata[7] && !match[0] && !flags[7]) |=> !flags[7]);
  assert_irq_on_enabled_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ien) != 8'h00) |-> irq);
endmodule

bind tmr_capcmp tmr_capcmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata), .cnt(cnt), .ctrl(ctrl),
  .flags(flags), .ien(ien), .ovf_f(ovf_f), .irq(irq), .match(match), .hit(hit), .sh_reg(cmpr[4])
);

// File: tb/tmr_capcmp_bench.sv
`timescale 1ns/1ps
module tmr_capcmp_bench;
  localparam logic [4:0] A_FLG = 5'h12, A_IEN = 5'h13, A_FRC = 5'h14, A_CTL = 5'h15,
                         A_ACT = 5'h16, A_EDG = 5'h17, A_OVF = 5'h18;
  logic clk = 0, rst_n = 0, wr = 0, rd = 0, sh_pin_in = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [2:0] cap_in = 0;
  logic sh_pin_out, sh_pin_oe, irq;
  logic [3:0] cmp_out;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] mc;
  logic [3:0] mk;
  logic [1:0] mps;
  logic [7:0] ctl = 0, actv = 0, edgv = 0;
  logic [4:0] lvl = 0;

  always #2.5 clk = ~clk;

  tmr_capcmp u_tmr_capcmp (.clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .sh_pin_in(sh_pin_in), .sh_pin_out(sh_pin_out),
    .sh_pin_oe(sh_pin_oe), .cmp_out(cmp_out), .irq(irq));

  // counter expectation from the divider rule
  always @(posedge clk) begin : model
    logic [3:0] m;
    if (!rst_n) begin mc = 0; mk = 0; mps = 0; end
    else begin
      m = {mps == 2'b11, mps[1], |mps, |mps};
      if ((mk & m) == m) mc = mc + 16'd1;
      mk = mk + 4'd1;
      if (wr && addr == A_CTL) mps = wdata[1:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask
  task automatic w8(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1; @(negedge clk); wr = 0;
  endtask
  task automatic r8(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata; @(negedge clk); rd = 0;
  endtask
  task automatic r16(input logic [4:0] a, output logic [15:0] v, output logic [15:0] m);
    @(negedge clk); addr = a; rd = 1; #1 v[15:8] = rdata; m = mc;
    @(negedge clk); addr = 5'(a + 1); #1 v[7:0] = rdata; @(negedge clk); rd = 0;
  endtask
  task automatic setctl(input logic [7:0] v); w8(A_CTL, v); ctl = v; endtask

  task automatic cmp_test(input int ch, input int it);
    logic [15:0] cur, m, tgt; logic [7:0] f; logic [1:0] a; logic el, outv; bit ok;
    a = 2'((it % 3) + 1);
    if (ch < 4) begin actv[2*ch +: 2] = 2'b00; w8(A_ACT, actv); end
    else begin ctl[5:4] = 2'b00; setctl(ctl); end
    r16(5'h00, cur, m);
    chk(cur == m, "R1 counter read", cur, m);
    tgt = cur + 16'd24;
    w8(5'(2 + 2*ch), tgt[15:8]); w8(5'(3 + 2*ch), tgt[7:0]);
    w8(A_FLG, 8'hFF); w8(A_IEN, 8'h80 >> ch);
    if (ch < 4) begin actv[2*ch +: 2] = a; w8(A_ACT, actv); end
    else begin ctl[5:4] = a; setctl(ctl); end
    el = (a == 2'b01) ? ~lvl[ch] : (a == 2'b11);
    ok = 1;
    for (int n = 0; n < 2000 && mc != tgt; n++) begin
      @(negedge clk); #1;
      if (irq !== (mc == tgt)) ok = 0;
    end
    chk(ok && mc == tgt, "R1 R3 R10 match timing", mc, tgt);
    outv = (ch < 4) ? cmp_out[ch] : sh_pin_out;
    chk(outv === el, "R4 compare action", outv, el);
    lvl[ch] = el;
    r8(A_FLG, f);
    chk(f == (8'h80 >> ch), "R6 compare flag position", f, 8'h80 >> ch);
    w8(A_IEN, 8'h00);
  endtask

  task automatic cap_edge(input int j, input int p, input bit rise);
    logic [15:0] em, v, m; logic [7:0] f, ef; bit exp;
    w8(A_FLG, 8'hFF);
    @(negedge clk); cap_in[j] = rise; em = mc;
    exp = rise ? p[0] : p[1];
    ef = exp ? (8'h04 >> j) : 8'h00;
    r8(A_FLG, f);
    chk(f == ef, "R5 capture edge select", f, ef);
    if (exp) begin
      r16(5'(12 + 2*j), v, m);
      chk(v == em, "R5 captured count", v, em);
    end
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R12 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] f; logic [15:0] v, m, em, hi_lo; logic [7:0] hi, lo, prv;
    repeat (3) @(negedge clk); rst_n = 1;
    // R12 reset state
    r8(A_FLG, f); chk(f == 0, "R12 flags", f, 0);
    r8(A_CTL, f); chk(f == 0, "R12 control", f, 0);
    chk(cmp_out == 0 && irq == 0 && sh_pin_oe == 0 && sh_pin_out == 0, "R12 outputs",
        {cmp_out, irq, sh_pin_oe, sh_pin_out}, 0);
    r16(5'h0A, v, m); chk(v == 0, "R12 shared register", v, 0);
    r16(5'h00, v, m); chk(v == m, "R1 R12 counter from reset", v, m);

    for (int ps = 0; ps < 4; ps++) begin
      setctl({ctl[7:2], 2'(ps)});
      for (int ch = 0; ch < 5; ch++) cmp_test(ch, ps * 5 + ch);
    end
    setctl({ctl[7:2], 2'b00});

    // R7 force
    actv = 8'b0000_0111; w8(A_ACT, actv); w8(A_FLG, 8'hFF);
    prv = {4'd0, cmp_out};
    w8(A_FRC, 8'h40);
    chk(cmp_out[1] == ~prv[1], "R7 force toggles compare 2", cmp_out[1], ~prv[1]);
    w8(A_FRC, 8'hC0);
    chk(cmp_out[0] == 1'b1 && cmp_out[1] == prv[1], "R7 force two channels", cmp_out[1:0], {prv[1], 1'b1});
    r8(A_FLG, f); chk(f == 0, "R7 force sets no flag", f, 0);

    // R5 capture sweep
    for (int p = 0; p < 4; p++)
      for (int j = 0; j < 3; j++) begin
        edgv = 8'h00; edgv[2*j +: 2] = 2'(p); w8(A_EDG, edgv);
        cap_edge(j, p, 1'b1);
        cap_edge(j, p, 1'b0);
      end

    // R6 write-one-to-clear, R10 enable gating
    edgv = 8'h01; w8(A_EDG, edgv); w8(A_FLG, 8'hFF);
    @(negedge clk); cap_in[0] = 1;
    w8(A_FLG, 8'h00); r8(A_FLG, f); chk(f == 8'h04, "R6 write zero keeps flag", f, 8'h04);
    chk(irq == 0, "R10 flag without enable", irq, 0);
    w8(A_IEN, 8'h04); #1 chk(irq == 1, "R10 flag with enable", irq, 1);
    w8(A_FLG, 8'h02); r8(A_FLG, f); chk(f == 8'h04, "R6 other bit clear", f, 8'h04);
    w8(A_FLG, 8'h04); r8(A_FLG, f); chk(f == 8'h00, "R6 write one clears", f, 0);
    #1 chk(irq == 0, "R10 irq drops", irq, 0);
    w8(A_IEN, 8'h00);

    // R8 shared channel in capture mode
    r16(5'h0A, em, m);
    setctl(ctl | 8'h04);
    w8(5'h0A, 8'h5A); w8(5'h0B, 8'hA5);
    r16(5'h0A, v, m); chk(v == em, "R8 bus write ignored", v, em);
    edgv = 8'h40; w8(A_EDG, edgv); w8(A_FLG, 8'hFF);
    @(negedge clk); sh_pin_in = 1; em = mc;
    r8(A_FLG, f); chk(f == 8'h08, "R8 shared capture flag", f, 8'h08);
    r16(5'h0A, v, m); chk(v == em, "R8 shared capture value", v, em);

    // R9 self-driven captures
    setctl(ctl | 8'h08);
    chk(sh_pin_oe == 1, "R9 pin output enable", sh_pin_oe, 1);
    w8(A_FLG, 8'hFF);
    setctl(ctl | 8'h40); em = mc;
    chk(sh_pin_out == 1, "R9 driven level", sh_pin_out, 1);
    r8(A_FLG, f); chk(f == 8'h08, "R9 own edge captured", f, 8'h08);
    r16(5'h0A, v, m); chk(v == em, "R9 own edge count", v, em);

    // R11 read snapshot
    @(negedge clk); addr = 5'h00; rd = 1; #1 hi = rdata; hi_lo = mc;
    @(negedge clk); rd = 0;
    repeat (7) @(negedge clk);
    addr = 5'h01; rd = 1; #1 lo = rdata;
    chk({hi, lo} == hi_lo, "R11 snapshot low byte", {hi, lo}, hi_lo);
    @(negedge clk); rd = 0;
    @(negedge clk); addr = 5'h01; rd = 1; #1 lo = rdata;
    chk(lo == mc[7:0], "R11 live low byte", lo, mc[7:0]);
    @(negedge clk); rd = 0;

    // R2 wrap and overflow flag
    w8(A_IEN, 8'h00); w8(A_OVF, 8'hC0);
    for (int n = 0; n < 70000 && mc != 16'hFFFF; n++) @(negedge clk);
    #1 chk(irq == 0 && mc == 16'hFFFF, "R2 before wrap", irq, 0);
    @(negedge clk); #1 chk(irq == 1 && mc == 16'h0000, "R2 R10 wrap interrupt", irq, 1);
    r8(A_OVF, f); chk(f == 8'hC0, "R2 overflow flag", f, 8'hC0);
    w8(A_OVF, 8'hC0); r8(A_OVF, f); chk(f == 8'h40, "R2 overflow clear", f, 8'h40);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule